// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register side of a general-purpose I/O controller. The pins are grouped in banks of eight. Each bank has two 8-bit registers. The data register holds the value that the bank drives. The direction register selects, for each line, whether the line is an input or an output. A simple 32-bit register bus with single-cycle read and write strobes reaches both registers in every bank.

On the pin side the block drives an output value and an output-enable for every line. It also samples the pad level of every line. A read of a data register returns a mix of two sources. Output lines return the stored drive value. Input lines return the pad level, taken after a two-flop synchronizer.

The bank registers do not sit at contiguous addresses. A fixed 16-byte window sits in the middle of the map for interrupt controls that live elsewhere. The bank map steps over that window, and this block decodes the window as a hole.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset, every direction bit is 1 (input) and every stored data bit is 0. padOe and padOut are all zero, and rdData is zero.
- R2: Line n belongs to bank n/8, at bit n%8 of that bank's registers and at bit n of the pin vectors. Bank b has a base byte address of (b+1)*8, plus 0x10 when that value is 0x90 or higher. The data register is at base+0 and the direction register is at base+4.
- R3: No register decodes at byte addresses 0x90 to 0x9F. A read there returns zero, and a write there changes no register.
- R4: Any other address that is not exactly a bank data or direction address reads as zero, and a write to it is ignored. This includes unaligned byte addresses, 0x00 to 0x07, and addresses past the last bank.
- R5: A direction bit of 1 makes the line an input, and its padOe bit is 0. A direction bit of 0 makes the line an output, and its padOe bit is 1. padOut always carries the stored data bit.
- R6: A data register read returns the stored bit for output lines and the synchronized pad level for input lines.
- R7: Each pad input passes through two flops. Suppose padIn changes before clock edge k. A read strobe sampled at edge k or k+1 returns the old level. A read strobe sampled at edge k+2 or later returns the new level.
- R8: A write to the data register also updates the stored bits of lines that are currently inputs. When such a line is switched to output, it drives the written value.
- R9: Read data is registered. It appears one cycle after the read strobe and holds until the next read. Bits 31:8 are always zero. If a read and a write hit the same register in the same cycle, the read returns the value from before the write.
- R10: A direction register read returns the stored direction bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte address |
| wrData | input | 32 | Write data; only bits 7:0 are stored |
| rdData | output | 32 | Registered read data |
| padIn | input | NUM_BANKS*8 | Pad levels, asynchronous |
| padOut | output | NUM_BANKS*8 | Drive value per line |
| padOe | output | NUM_BANKS*8 | Output enable per line |

## Verification
The bench goes after the hole and the banks on either side of it. A decoder that forgot the skip would alias bank 17 onto 0x90, and one that skipped it wrongly would lose bank 17 or shift every higher bank. It also probes unaligned addresses and addresses past the last bank, where a loose decoder would write a bank.

The bench steps a pad level past the synchronizer one read at a time. A design with one flop shows the new level a cycle early, and a design with three flops shows it a cycle late. It stores a value into an input line and then flips the line to output. A design that masks writes by direction would drive the old value.

A read and a write that land on the same register in the same cycle must return the old contents. A design that bypassed the write into the read would show the new value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned LINES_PER_BANK = 8;
  localparam int unsigned BANK_STRIDE    = 8;
  localparam int unsigned DIR_OFS        = 4;
  localparam int unsigned HOLE_LO        = 'h90;
  localparam int unsigned HOLE_HI        = 'h9F;
  localparam int unsigned HOLE_SKIP      = 'h10;
  localparam int unsigned BUS_W          = 32;

  // strobes from the address decoder to the register datapath
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdData;
    logic rdDir;
    logic rdAny;
  } strobe_t;

  // base byte address of a bank, stepping over the reserved window
  function automatic int unsigned bankBase(input int unsigned b);
    int unsigned r;
    r = (b + 1) * BANK_STRIDE;
    if (r >= HOLE_LO) r = r + HOLE_SKIP;
    return r;
  endfunction
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 8,
  parameter int SEL_W     = 5
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe,
  output logic [SEL_W-1:0]  bankSel
);
  logic [NUM_BANKS-1:0] hitData;
  logic [NUM_BANKS-1:0] hitDir;
  logic inHole;
  logic anyData;
  logic anyDir;

  assign inHole = (32'(addr) >= HOLE_LO) && (32'(addr) <= HOLE_HI);

  // one comparator pair per bank; banks whose address would not fit are dropped
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
      localparam int unsigned BASE = bankBase(b);
      localparam bit FITS = (BASE + DIR_OFS) < (2 ** ADDR_W);
      assign hitData[b] = FITS && (32'(addr) == BASE);
      assign hitDir[b]  = FITS && (32'(addr) == BASE + DIR_OFS);
    end
  endgenerate

  assign anyData = (|hitData) && !inHole;
  assign anyDir  = (|hitDir) && !inHole;

  always_comb begin
    bankSel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hitData[b] || hitDir[b]) bankSel = SEL_W'(b);
    end
  end

  assign strobe.wrData = wrEn && anyData;
  assign strobe.wrDir  = wrEn && anyDir;
  assign strobe.rdData = rdEn && anyData;
  assign strobe.rdDir  = rdEn && anyDir;
  assign strobe.rdAny  = rdEn;
endmodule

// File: rtl/gpio_bank_store.sv
module gpio_bank_store
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int SEL_W     = 5,
  parameter int NUM_LINES = NUM_BANKS * LINES_PER_BANK
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobe,
  input  logic [SEL_W-1:0]          bankSel,
  input  logic [LINES_PER_BANK-1:0] wrByte,
  input  logic [NUM_LINES-1:0]      padIn,
  output logic [NUM_LINES-1:0]      padOut,
  output logic [NUM_LINES-1:0]      padOe,
  output logic [BUS_W-1:0]          rdData
);
  logic [NUM_LINES-1:0] dataVec;
  logic [NUM_LINES-1:0] dirVec;
  logic [NUM_LINES-1:0] syncA;
  logic [NUM_LINES-1:0] syncB;
  logic [BUS_W-1:0]     rdQ;
  logic [BUS_W-1:0]     rdNext;
  logic [LINES_PER_BANK-1:0] dataB;
  logic [LINES_PER_BANK-1:0] dirB;
  logic [LINES_PER_BANK-1:0] pinB;
  logic [LINES_PER_BANK-1:0] mixB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataVec <= '0;
      dirVec  <= '1;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strobe.wrData && (bankSel == SEL_W'(b)))
          dataVec[b*LINES_PER_BANK +: LINES_PER_BANK] <= wrByte;
        if (strobe.wrDir && (bankSel == SEL_W'(b)))
          dirVec[b*LINES_PER_BANK +: LINES_PER_BANK] <= wrByte;
      end
    end
  end

  // two-stage synchronizer on every pad input
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    dataB = dataVec[bankSel*LINES_PER_BANK +: LINES_PER_BANK];
    dirB  = dirVec[bankSel*LINES_PER_BANK +: LINES_PER_BANK];
    pinB  = syncB[bankSel*LINES_PER_BANK +: LINES_PER_BANK];
    mixB  = (dirB & pinB) | (~dirB & dataB);
    if (strobe.rdData)     rdNext = BUS_W'(mixB);
    else if (strobe.rdDir) rdNext = BUS_W'(dirB);
    else                   rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdQ <= '0;
    else if (strobe.rdAny) rdQ <= rdNext;
  end

  assign padOut = dataVec;
  assign padOe  = ~dirVec;
  assign rdData = rdQ;
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                wrEn,
  input  logic                                rdEn,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [31:0]                         wrData,
  output logic [31:0]                         rdData,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0] padIn,
  output logic [NUM_BANKS*LINES_PER_BANK-1:0] padOut,
  output logic [NUM_BANKS*LINES_PER_BANK-1:0] padOe
);
  localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;

  strobe_t          strobe;
  logic [SEL_W-1:0] bankSel;
  logic             unusedWrHi;

  assign unusedWrHi = ^wrData[31:LINES_PER_BANK];

  gpio_bank_decode #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) uDecode (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .strobe(strobe), .bankSel(bankSel)
  );

  gpio_bank_store #(
    .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W), .NUM_LINES(NUM_LINES)
  ) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankSel(bankSel),
    .wrByte(wrData[LINES_PER_BANK-1:0]), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .rdData(rdData)
  );
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 8
) (
  input logic                                clk,
  input logic                                rstN,
  input logic                                wrEn,
  input logic                                rdEn,
  input logic [ADDR_W-1:0]                   addr,
  input logic [LINES_PER_BANK-1:0]           wrLow,
  input logic [31:0]                         rdData,
  input logic [NUM_BANKS*LINES_PER_BANK-1:0] padOut,
  input logic [NUM_BANKS*LINES_PER_BANK-1:0] padOe
);
  logic inHole;
  assign inHole = (32'(addr) >= HOLE_LO) && (32'(addr) <= HOLE_HI);

  assert_reset_outputs_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && padOut == '0 && rdData == '0));

  assert_hole_write_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && inHole) |=> ($stable(padOut) && $stable(padOe)));

  assert_hole_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && inHole) |=> (rdData == '0));

  assert_unaligned_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[1:0] != 2'b00) |=> (rdData == '0));

  assert_dir_sets_oe_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && 32'(addr) == bankBase(0) + DIR_OFS) |=> (padOe[7:0] == ~$past(wrLow)));

  assert_data_drives_pad_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && 32'(addr) == bankBase(0)) |=> (padOut[7:0] == $past(wrLow)));

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:8] == '0);
endmodule

bind gpio_bank_regfile gpio_bank_checker #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrLow(wrData[7:0]), .rdData(rdData), .padOut(padOut), .padOe(padOe)
);

// File: tb/sim_gpio_bank_regfile.sv
module sim_gpio_bank_regfile;
  localparam int NB = 20;
  localparam int AW = 8;
  localparam int NL = NB * 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NL-1:0] padIn = '0;
  logic [NL-1:0] padOut;
  logic [NL-1:0] padOe;

  gpio_bank_regfile #(.NUM_BANKS(NB), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [7:0] mData [NB];
  logic [7:0] mDir  [NB];

  function automatic int baseOf(input int b);
    int r;
    r = (b + 1) * 8;
    if (r >= 'h90) r = r + 'h10;
    return r;
  endfunction

  function automatic logic [31:0] expData(input int b);
    return {24'h0, (mDir[b] & padIn[b*8 +: 8]) | (~mDir[b] & mData[b])};
  endfunction

  function automatic logic [NL-1:0] modelOut();
    logic [NL-1:0] v;
    for (int b = 0; b < NB; b++) v[b*8 +: 8] = mData[b];
    return v;
  endfunction

  function automatic logic [NL-1:0] modelOe();
    logic [NL-1:0] v;
    for (int b = 0; b < NB; b++) v[b*8 +: 8] = ~mDir[b];
    return v;
  endfunction

  task automatic note(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input int a, input logic [31:0] d);
    for (int b = 0; b < NB; b++) begin
      if (a == baseOf(b))     mData[b] = d[7:0];
      if (a == baseOf(b) + 4) mDir[b]  = d[7:0];
    end
  endtask

  // all driver tasks start and end at a falling edge
  task automatic wr(input int a, input logic [31:0] d);
    addr = AW'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    addr = AW'(a); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdwr(input int a, input logic [31:0] d, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    addr = AW'(a); wrData = d; rdEn = 1'b1; wrEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  // monitor: a read sampled at a rising edge is compared at the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn && rstN) begin
        @(negedge clk);
        if (q.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL R9 unexpected read actual=%h expected=none", rdData);
        end else begin
          item_t it;
          it = q.pop_front();
          note(it.tag, NL'(rdData), NL'(it.exp));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] snapOut;
    logic [NL-1:0] snapOe;
    for (int b = 0; b < NB; b++) begin mData[b] = 8'h00; mDir[b] = 8'hFF; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    note("R1 padOe", padOe, '0);
    note("R1 padOut", padOut, '0);
    note("R1 rdData", NL'(rdData), '0);
    rd(baseOf(0) + 4, 32'hFF, "R1 dir bank0");
    rd(baseOf(NB - 1), 32'h0, "R1 data last bank");

    // R2, R5: program every bank through its mapped addresses
    for (int b = 0; b < NB; b++) begin
      wr(baseOf(b), 32'hFFFF_FF00 | 32'(8'(b * 37 + 5)));
      wr(baseOf(b) + 4, 32'(~8'(b * 11)));
    end
    note("R2 padOut map", padOut, modelOut());
    note("R5 padOe map", padOe, modelOe());

    // R6, R10: mixed read-back with a pad pattern
    for (int i = 0; i < NL / 8; i++) padIn[i*8 +: 8] = 8'(i * 29 + 60);
    repeat (3) @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      rd(baseOf(b), expData(b), "R6 data mix");
      rd(baseOf(b) + 4, {24'h0, mDir[b]}, "R10 dir read");
    end

    // R3: the reserved window decodes nothing
    snapOut = padOut; snapOe = padOe;
    for (int a = 'h90; a <= 'h9C; a += 4) wr(a, 32'hFF);
    wr('h90, 32'h00);
    note("R3 padOut after hole writes", padOut, snapOut);
    note("R3 padOe after hole writes", padOe, snapOe);
    for (int a = 'h90; a <= 'h9C; a += 4) rd(a, 32'h0, "R3 hole read");
    rd(baseOf(16) + 4, {24'h0, mDir[16]}, "R2 bank16 below hole");
    rd(baseOf(17), expData(17), "R2 bank17 above hole");

    // R4: other unmapped addresses
    wr('h01, 32'h00); wr('h00, 32'h00); wr('h04, 32'h00);
    wr(baseOf(NB - 1) + 8, 32'h00); wr(baseOf(3) + 2, 32'h00);
    note("R4 padOut after stray writes", padOut, snapOut);
    note("R4 padOe after stray writes", padOe, snapOe);
    rd('h00, 32'h0, "R4 addr 0x00");
    rd('h04, 32'h0, "R4 addr 0x04");
    rd(baseOf(0) + 1, 32'h0, "R4 unaligned");
    rd(baseOf(NB - 1) + 8, 32'h0, "R4 past last bank");

    // R7: synchronizer latency on bank 0, all inputs
    wr(baseOf(0) + 4, 32'hFF);
    padIn[7:0] = 8'h00;
    repeat (3) @(negedge clk);
    padIn[7:0] = 8'h5A;
    rd(baseOf(0), 32'h00, "R7 edge k old");
    rd(baseOf(0), 32'h00, "R7 edge k+1 old");
    rd(baseOf(0), 32'h5A, "R7 edge k+2 new");

    // R8: write data while input, then switch to output
    wr(baseOf(1) + 4, 32'hFF);
    padIn[15:8] = 8'h0F;
    wr(baseOf(1), 32'hC3);
    repeat (2) @(negedge clk);
    note("R8 oe still off", NL'(padOe[15:8]), NL'(8'h00));
    note("R8 stored value on padOut", NL'(padOut[15:8]), NL'(8'hC3));
    rd(baseOf(1), 32'h0F, "R8 input reads pad");
    wr(baseOf(1) + 4, 32'h00);
    note("R8 oe on", NL'(padOe[15:8]), NL'(8'hFF));
    rd(baseOf(1), 32'hC3, "R8 output reads stored");

    // R9: read and write same register in one cycle, then hold
    rdwr(baseOf(2) + 4, 32'hABCD_EF12, {24'h0, mDir[2]}, "R9 read-before-write");
    rd(baseOf(2) + 4, 32'h12, "R9 new value and upper zero");
    repeat (3) @(negedge clk);
    note("R9 hold after idle", NL'(rdData), NL'(32'h12));

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R9 missing reads actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule